// File: doc/BRIEF.md
# Crypto Engine Control and Ownership Register Bank

This block is an APB slave that sits beside a cryptographic engine. It holds the engine's control levels, the seed for its stall logic and the top address bits that its bus master needs. Software on the processor side sets reset, purge, go, oscillator enable, streaming enable and stall settings through one control word. It reads back the engine's completion, alarm, bus error and busy status through the same word.

The engine can be used by only one party at a time: the on-chip processor or the programmable fabric. The processor raises request and release through two control bits. The fabric drives two request/release pins. A small arbiter grants the engine to exactly one side. The grant holds until that side releases the engine, and a request that arrives while the engine is taken waits. When both sides ask in the same cycle, the processor is granted.

Streaming to the fabric is live when the stream enable bit is set and either the fabric owns the engine, or the processor owns it with the fabric clock selected.

Top module: `crypto_ctrl_regs`

## Requirements
- R1: After reset the control word reads 0x00000001, the engine reset output is high, the seed and upper-address registers read 0, and neither owner output is set.
- R2: A write to offset 0x00 sets these control fields one clock edge later: engine reset (bit 0), purge (1), go (2), oscillator enable (3), stream enable (4), internal stall mode (5), stall rate (7:6), fabric clock select (16), processor request (24) and processor release (25). Each field reads back at the same position and drives its output.
- R3: In the control word, writes to bits 8-15, 17-23 and 26-31 are ignored. Bits 13-15, 17-23 and 30-31 always read 0.
- R4: Control bits 8, 9, 10 and 12 read the complete, alarm, bus error and busy inputs as sampled on the previous clock edge.
- R5: Control bit 11 and the stream output are high only when stream enable is set and either the fabric owns the engine, or the processor owns it with bit 16 set.
- R6: Offset 0x04 is a 32-bit read/write seed register that drives the stall seed output.
- R7: Offset 0x08 keeps only bits 5:0 of a write. It drives engine address bits 37:32, and its bits 31:6 read 0.
- R8: With no owner, a side that requests without releasing is granted. The processor wins a tie. The processor owner flag is bit 28 and the fabric owner flag is bit 29. Control bits 26/27 show the sampled fabric request/release. A processor grant appears on the second edge after the control write; a fabric grant appears on the second edge after the pin changes.
- R9: The owner keeps the engine until it asserts release, and a request from the other side meanwhile stays pending. Once the engine is released it first returns to no owner, then on the next edge it grants the pending side.
- R10: The two owner outputs are never high at the same time.
- R11: PREADY is always high and PSLVERR always low. Any other address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| eng_rst_o | output | 1 | Engine reset level |
| eng_purge_o | output | 1 | Engine purge command |
| eng_go_o | output | 1 | Engine go |
| osc_en_o | output | 1 | Ring oscillator enable |
| stream_en_o | output | 1 | Streaming interface live |
| stall_int_o | output | 1 | 1: internal stall generator, 0: fabric stall pin |
| stall_rate_o | output | 2 | Average stall rate: 0 = 1/8, 1 = 1/16, 2 = 1/32, 3 = 1/64 |
| fab_clk_sel_o | output | 1 | Use fabric clock while processor owns |
| stall_seed_o | output | 32 | Stall logic seed |
| addr_upper_o | output | 6 | Engine master address bits 37:32 |
| eng_complete_i | input | 1 | Engine complete status |
| eng_alarm_i | input | 1 | Engine alarm status |
| eng_buserr_i | input | 1 | Engine bus error status |
| eng_busy_i | input | 1 | Engine busy status |
| fab_req_i | input | 1 | Fabric requests the engine |
| fab_rel_i | input | 1 | Fabric releases the engine |
| cpu_own_o | output | 1 | Processor owns the engine |
| fab_own_o | output | 1 | Fabric owns the engine |

## Verification
Register fields and their outputs change on the access edge of an APB write. Read data is combinational, so the bench samples it on the falling edge inside the access phase. Status and fabric pins pass through one capture flop, so their effect is read one edge later. An owner flag moves two edges after the processor write or the fabric pin change, and a grant to the waiting side comes one further edge after a release. The bench waits exactly those falling edges before comparing owner outputs, including the same-cycle tie, where the fabric pin is raised in the access phase of the processor's request write.

// File: rtl/crypto_ctrl_pkg.sv
package crypto_ctrl_pkg;
  localparam int DATA_W  = 32;
  localparam int UPPER_W = 6;

  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_SEED  = 12'h004;
  localparam logic [11:0] OFF_UPPER = 12'h008;

  // control word bit positions
  localparam int B_RST      = 0;
  localparam int B_PURGE    = 1;
  localparam int B_GO       = 2;
  localparam int B_OSC      = 3;
  localparam int B_STREAM   = 4;
  localparam int B_STALL    = 5;
  localparam int B_RATE_LO  = 6;
  localparam int B_COMPLETE = 8;
  localparam int B_ALARM    = 9;
  localparam int B_BUSERR   = 10;
  localparam int B_LIVE     = 11;
  localparam int B_BUSY     = 12;
  localparam int B_FCLK     = 16;
  localparam int B_CREQ     = 24;
  localparam int B_CREL     = 25;
  localparam int B_FREQ     = 26;
  localparam int B_FREL     = 27;
  localparam int B_COWN     = 28;
  localparam int B_FOWN     = 29;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0301_00FF;
  localparam logic [DATA_W-1:0] CTRL_RST   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] CTRL_RSVD  = 32'hC0FE_E000;

  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_CPU = 2'd1, OWN_FAB = 2'd2} own_e;

  typedef struct packed {
    logic busy;
    logic buserr;
    logic alarm;
    logic complete;
  } eng_stat_t;
endpackage

// File: rtl/crypto_in_capture.sv
module crypto_in_capture #(
  parameter int W      = 6,
  parameter int STAGES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/crypto_own_arb.sv
module crypto_own_arb import crypto_ctrl_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic cpu_rel_i,
  input  logic fab_req_i,
  input  logic fab_rel_i,
  output logic cpu_own_o,
  output logic fab_own_o
);
  own_e state_q, state_d;
  logic cpu_want, fab_want;

  assign cpu_want = cpu_req_i & ~cpu_rel_i;
  assign fab_want = fab_req_i & ~fab_rel_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_NONE: if (cpu_want) state_d = OWN_CPU;   // processor wins ties
                else if (fab_want) state_d = OWN_FAB;
      OWN_CPU:  if (cpu_rel_i) state_d = OWN_NONE;
      OWN_FAB:  if (fab_rel_i) state_d = OWN_NONE;
      default:  state_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OWN_NONE;
    else         state_q <= state_d;
  end

  assign cpu_own_o = (state_q == OWN_CPU);
  assign fab_own_o = (state_q == OWN_FAB);

  assert_owner_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_own_o && fab_own_o));
  assert_cpu_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_own_o && !cpu_rel_i |=> cpu_own_o);
  assert_fab_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fab_own_o && !fab_rel_i |=> fab_own_o);
  assert_tie_cpu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_own_o && !fab_own_o && cpu_want |=> cpu_own_o);
  assert_fab_from_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fab_own_o) |-> !$past(cpu_own_o));
endmodule

// File: rtl/crypto_reg_bank.sv
module crypto_reg_bank import crypto_ctrl_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  eng_stat_t         stat_i,
  input  logic              fab_req_i,
  input  logic              fab_rel_i,
  input  logic              cpu_own_i,
  input  logic              fab_own_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              live_o,
  output logic [DATA_W-1:0] seed_o,
  output logic [UPPER_W-1:0] upper_o
);
  logic wr_acc;
  logic sel_ctrl, sel_seed, sel_upper;
  logic [DATA_W-1:0]  ctrl_q, seed_q, stat_word;
  logic [UPPER_W-1:0] upper_q;

  assign wr_acc    = psel_i & penable_i & pwrite_i;
  assign sel_ctrl  = (paddr_i == ADDR_W'(OFF_CTRL));
  assign sel_seed  = (paddr_i == ADDR_W'(OFF_SEED));
  assign sel_upper = (paddr_i == ADDR_W'(OFF_UPPER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      seed_q  <= '0;
      upper_q <= '0;
    end else if (wr_acc) begin
      if (sel_ctrl)  ctrl_q  <= pwdata_i & CTRL_WMASK;
      if (sel_seed)  seed_q  <= pwdata_i;
      if (sel_upper) upper_q <= pwdata_i[UPPER_W-1:0];
    end
  end

  assign live_o = ctrl_q[B_STREAM] & (fab_own_i | (cpu_own_i & ctrl_q[B_FCLK]));

  always_comb begin
    stat_word             = '0;
    stat_word[B_COMPLETE] = stat_i.complete;
    stat_word[B_ALARM]    = stat_i.alarm;
    stat_word[B_BUSERR]   = stat_i.buserr;
    stat_word[B_LIVE]     = live_o;
    stat_word[B_BUSY]     = stat_i.busy;
    stat_word[B_FREQ]     = fab_req_i;
    stat_word[B_FREL]     = fab_rel_i;
    stat_word[B_COWN]     = cpu_own_i;
    stat_word[B_FOWN]     = fab_own_i;
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i) begin
      if (sel_ctrl)       prdata_o = ctrl_q | stat_word;
      else if (sel_seed)  prdata_o = seed_q;
      else if (sel_upper) prdata_o = DATA_W'(upper_q);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign seed_o  = seed_q;
  assign upper_o = upper_q;

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_i && sel_ctrl |-> (prdata_o & CTRL_RSVD) == '0);
  assert_seed_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_acc && sel_seed) |=> $stable(seed_o));
  assert_upper_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_acc && sel_upper) |=> $stable(upper_o));
  assert_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |-> (cpu_own_i || fab_own_i));
endmodule

// File: rtl/crypto_ctrl_regs.sv
module crypto_ctrl_regs import crypto_ctrl_pkg::*; #(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  output logic               eng_rst_o,
  output logic               eng_purge_o,
  output logic               eng_go_o,
  output logic               osc_en_o,
  output logic               stream_en_o,
  output logic               stall_int_o,
  output logic [1:0]         stall_rate_o,
  output logic               fab_clk_sel_o,
  output logic [DATA_W-1:0]  stall_seed_o,
  output logic [UPPER_W-1:0] addr_upper_o,
  input  logic               eng_complete_i,
  input  logic               eng_alarm_i,
  input  logic               eng_buserr_i,
  input  logic               eng_busy_i,
  input  logic               fab_req_i,
  input  logic               fab_rel_i,
  output logic               cpu_own_o,
  output logic               fab_own_o
);
  localparam int CAP_W = $bits(eng_stat_t) + 2;

  logic [CAP_W-1:0]  cap_d, cap_q;
  eng_stat_t         stat_q;
  logic              fab_req_q, fab_rel_q;
  logic [DATA_W-1:0] ctrl;
  logic              cpu_own, fab_own;

  assign cap_d = {fab_rel_i, fab_req_i, eng_busy_i, eng_buserr_i, eng_alarm_i, eng_complete_i};

  crypto_in_capture #(.W(CAP_W), .STAGES(SYNC_STAGES)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_d),
    .q_o    (cap_q)
  );

  assign stat_q    = cap_q[$bits(eng_stat_t)-1:0];
  assign fab_req_q = cap_q[CAP_W-2];
  assign fab_rel_q = cap_q[CAP_W-1];

  crypto_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .stat_i    (stat_q),
    .fab_req_i (fab_req_q),
    .fab_rel_i (fab_rel_q),
    .cpu_own_i (cpu_own),
    .fab_own_i (fab_own),
    .ctrl_o    (ctrl),
    .live_o    (stream_en_o),
    .seed_o    (stall_seed_o),
    .upper_o   (addr_upper_o)
  );

  crypto_own_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_req_i (ctrl[B_CREQ]),
    .cpu_rel_i (ctrl[B_CREL]),
    .fab_req_i (fab_req_q),
    .fab_rel_i (fab_rel_q),
    .cpu_own_o (cpu_own),
    .fab_own_o (fab_own)
  );

  assign eng_rst_o     = ctrl[B_RST];
  assign eng_purge_o   = ctrl[B_PURGE];
  assign eng_go_o      = ctrl[B_GO];
  assign osc_en_o      = ctrl[B_OSC];
  assign stall_int_o   = ctrl[B_STALL];
  assign stall_rate_o  = ctrl[B_RATE_LO+1:B_RATE_LO];
  assign fab_clk_sel_o = ctrl[B_FCLK];
  assign cpu_own_o     = cpu_own;
  assign fab_own_o     = fab_own;
  assign pready_o      = 1'b1;
  assign pslverr_o     = 1'b0;

  assert_apb_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_i |-> pready_o && !pslverr_o);
endmodule

// File: tb/sim_crypto_ctrl_regs.sv
`timescale 1ns/1ps
module sim_crypto_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic eng_rst, eng_purge, eng_go, osc_en, stream_en, stall_int, fab_clk_sel;
  logic [1:0] stall_rate;
  logic [31:0] seed;
  logic [5:0] upper;
  logic st_c = 0, st_a = 0, st_e = 0, st_b = 0, freq = 0, frel = 0;
  logic cpu_own, fab_own;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  crypto_ctrl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .eng_rst_o(eng_rst), .eng_purge_o(eng_purge), .eng_go_o(eng_go), .osc_en_o(osc_en),
    .stream_en_o(stream_en), .stall_int_o(stall_int), .stall_rate_o(stall_rate),
    .fab_clk_sel_o(fab_clk_sel), .stall_seed_o(seed), .addr_upper_o(upper),
    .eng_complete_i(st_c), .eng_alarm_i(st_a), .eng_buserr_i(st_e), .eng_busy_i(st_b),
    .fab_req_i(freq), .fab_rel_i(frel), .cpu_own_o(cpu_own), .fab_own_o(fab_own));

  function automatic logic [31:0] exp_ctrl_rd(input logic [31:0] wr, input logic [3:0] st);
    // st = {busy, buserr, alarm, complete}; idle ownership, no fabric pins
    return (wr & 32'h0301_00FF) | {19'd0, st[3], 1'b0, st[2:0], 8'd0};
  endfunction

  function automatic logic [9:0] exp_outs(input logic [31:0] wr);
    return {wr[16], wr[7:6], wr[5], wr[3], wr[2], wr[1], wr[0], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input bit fab_tie = 0);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; if (fab_tie) freq = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    chk("R11 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd, d, s;
    logic [3:0] st;
    void'($urandom(32'h5eed_c0de));
    wait_neg(3); rst_n = 1; wait_neg(1);

    // R1 reset state
    apb_rd(12'h000, rd); chk("R1 ctrl reset", rd, 32'h1);
    apb_rd(12'h004, rd); chk("R1 seed reset", rd, 0);
    apb_rd(12'h008, rd); chk("R1 upper reset", rd, 0);
    chk("R1 eng_rst/owners", {29'd0, eng_rst, cpu_own, fab_own}, 32'h4);

    // R2 R3 random control writes, request/release cleared to stay idle
    for (int i = 0; i < 20; i++) begin
      d = $urandom() & ~32'h0300_0000;
      apb_wr(12'h000, d);
      chk("R2 outputs", {22'd0, fab_clk_sel, stall_rate, stall_int, osc_en, eng_go, eng_purge, eng_rst, 2'b00},
          {22'd0, exp_outs(d)});
      apb_rd(12'h000, rd); chk("R2 R3 ctrl readback", rd, exp_ctrl_rd(d, 4'h0));
    end

    // R6 seed
    for (int i = 0; i < 5; i++) begin
      d = $urandom();
      apb_wr(12'h004, d);
      chk("R6 seed out", seed, d);
      apb_rd(12'h004, rd); chk("R6 seed read", rd, d);
    end

    // R7 upper address
    apb_wr(12'h008, 32'hFFFF_FFFF);
    apb_rd(12'h008, rd); chk("R7 upper all ones", rd, 32'h3F);
    d = $urandom();
    apb_wr(12'h008, d);
    chk("R7 upper out", {26'd0, upper}, {26'd0, d[5:0]});

    // R4 status capture
    apb_wr(12'h000, 32'h0);
    for (int i = 0; i < 8; i++) begin
      st = 4'($urandom());
      @(negedge clk); {st_b, st_e, st_a, st_c} = st;
      apb_rd(12'h000, rd); chk("R4 status bits", rd, exp_ctrl_rd(32'h0, st));
    end
    @(negedge clk); {st_b, st_e, st_a, st_c} = 4'h0;

    // R3 all-ones write: read-only and reserved stay clear, release blocks a grant
    apb_wr(12'h000, 32'hFFFF_FFFF);
    wait_neg(2);
    apb_rd(12'h000, rd); chk("R3 all ones", rd, 32'h0301_00FF);
    chk("R3 no owner", {30'd0, cpu_own, fab_own}, 0);

    // R11 unmapped address
    apb_rd(12'h004, s);
    apb_wr(12'h00C, 32'hDEAD_BEEF);
    apb_rd(12'h00C, rd); chk("R11 unmapped read", rd, 0);
    apb_rd(12'h004, rd); chk("R11 seed untouched", rd, s);
    apb_wr(12'h006, 32'h1234_5678);
    apb_rd(12'h004, rd); chk("R11 unaligned no write", rd, s);

    // R8 processor grant from idle
    apb_wr(12'h000, 32'h0100_0000);
    chk("R8 not yet granted", {31'd0, cpu_own}, 0);
    wait_neg(1);
    chk("R8 cpu granted", {30'd0, cpu_own, fab_own}, 32'h2);
    apb_rd(12'h000, rd); chk("R8 owner bit 28", rd, 32'h1100_0000);

    // R5 stream live rules under processor ownership
    apb_wr(12'h000, 32'h0100_0010);
    chk("R5 no fab clk", {31'd0, stream_en}, 0);
    apb_wr(12'h000, 32'h0101_0010);
    chk("R5 fab clk", {31'd0, stream_en}, 1);
    apb_rd(12'h000, rd); chk("R5 live bit 11", rd, 32'h1101_0810);

    // R9 fabric request pending while processor holds
    @(negedge clk); freq = 1;
    wait_neg(4);
    chk("R9 cpu holds", {30'd0, cpu_own, fab_own}, 32'h2);
    apb_rd(12'h000, rd); chk("R8 fab req bit 26", rd, 32'h1501_0810);

    // R9 release hands over to pending fabric
    apb_wr(12'h000, 32'h0200_0010);
    wait_neg(1);
    chk("R9 idle between", {30'd0, cpu_own, fab_own}, 0);
    wait_neg(1);
    chk("R9 fab granted", {30'd0, cpu_own, fab_own}, 32'h1);
    chk("R5 fab owner live", {31'd0, stream_en}, 1);
    apb_rd(12'h000, rd); chk("R8 fab owner bit 29", rd, 32'h2600_0810);

    // R9 processor request pending while fabric holds
    apb_wr(12'h000, 32'h0100_0000);
    wait_neg(3);
    chk("R9 fab holds", {30'd0, cpu_own, fab_own}, 32'h1);
    @(negedge clk); freq = 0; frel = 1;
    wait_neg(3);
    chk("R9 cpu after fab release", {30'd0, cpu_own, fab_own}, 32'h2);
    @(negedge clk); frel = 0;

    // R8 tie: both request in the same cycle from idle
    apb_wr(12'h000, 32'h0200_0000);
    wait_neg(3);
    chk("R8 idle before tie", {30'd0, cpu_own, fab_own}, 0);
    apb_wr(12'h000, 32'h0100_0000, 1);
    wait_neg(1);
    chk("R8 tie to cpu", {30'd0, cpu_own, fab_own}, 32'h2);
    chk("R10 exclusive", {31'd0, cpu_own & fab_own}, 0);
    @(negedge clk); freq = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule